// File: doc/BRIEF.md
# Registered Stream Chain Tap

One stage of a daisy chain of stream slaves that share a single bus master. Two lanes run through the stage, and each lane has its own hop register.

The write lane carries packets from the master toward the far end of the chain. At this stage each write-lane beat is sorted by its destination field:

- A beat addressed to this stage goes to the attached compute kernel.
- A beat addressed to the broadcast identifier goes to the kernel and is also passed along the chain.
- Any other beat is passed along unchanged.

The read lane carries result packets back toward the master. The stage forwards packets that arrive from further down the chain. It may insert its own kernel's packet when the 4-bit access token, which the master distributes alongside the read lane, names this stage. Once a packet of either kind has started, it runs to its last beat without interruption.

Each output of the stage comes from a two-entry skid register. Every ready signal that leaves the stage is therefore backed by registered state. One beat per cycle keeps flowing under backpressure, and a beat accepted at a stage input appears at the next stage after exactly one clock edge.

Top module: `chain_tap`

## Requirements
- R1: A write-lane beat whose destination equals SLAVE_ID appears only on the local receive port, with all fields unchanged. Nothing is sent downstream for it.
- R2: A write-lane beat whose destination is neither SLAVE_ID nor BCAST_ID (default 4'hF) is passed downstream with data, keep, last, id, destination and user unchanged, and is not delivered locally.
- R3: A write-lane beat whose destination equals BCAST_ID appears both on the local receive port and downstream, as identical beats in the same order.
- R4: A broadcast beat is accepted only when both the local output and the downstream output can take it. While either output is full, wr_in_ready_o stays low for that beat.
- R5: Every output is registered. A beat accepted at an input edge becomes valid at the output after that edge. A valid output that is not accepted holds its fields stable.
- R6: Each output holds at most two beats. With its consumer stalled, an output accepts exactly two beats and then blocks. With the consumer ready, beats pass at one per cycle, with none lost or duplicated.
- R7: A local packet may start on the read lane only in a cycle where rd_tok_i equals SLAVE_ID. Otherwise loc_tx_ready_o stays low and nothing is inserted.
- R8: Once a packet from downstream has started going upstream, local beats are held off until that packet's last beat has been accepted, even across idle gaps on rd_in.
- R9: Once a local packet has started, downstream read traffic is held off until its last beat, even if the token changes or the kernel pauses.
- R10: Locally inserted read-lane beats carry id = SLAVE_ID and dest = loc_tx_dest_i. Forwarded read-lane beats keep their own id and dest.
- R11: rd_tok_o equals rd_tok_i delayed by one clock.
- R12: After reset all valid outputs are low, wr_in_ready_o is high and rd_tok_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_in_valid_i | input | 1 | Write-lane beat valid from the upstream stage |
| wr_in_ready_o | output | 1 | Write-lane ready to the upstream stage |
| wr_in_data_i | input | 64 | Write-lane data |
| wr_in_keep_i | input | 8 | Write-lane byte keep |
| wr_in_last_i | input | 1 | Write-lane last beat of packet |
| wr_in_id_i | input | 4 | Write-lane source id |
| wr_in_dest_i | input | 4 | Write-lane destination |
| wr_in_user_i | input | 4 | Write-lane user field |
| wr_out_valid_o | output | 1 | Write-lane beat valid to the downstream stage |
| wr_out_ready_i | input | 1 | Downstream write-lane ready |
| wr_out_data_o | output | 64 | Downstream write-lane data |
| wr_out_keep_o | output | 8 | Downstream write-lane keep |
| wr_out_last_o | output | 1 | Downstream write-lane last |
| wr_out_id_o | output | 4 | Downstream write-lane id |
| wr_out_dest_o | output | 4 | Downstream write-lane destination |
| wr_out_user_o | output | 4 | Downstream write-lane user field |
| loc_rx_valid_o | output | 1 | Beat valid to the kernel |
| loc_rx_ready_i | input | 1 | Kernel ready |
| loc_rx_data_o | output | 64 | Data to the kernel |
| loc_rx_keep_o | output | 8 | Keep to the kernel |
| loc_rx_last_o | output | 1 | Last to the kernel |
| loc_rx_id_o | output | 4 | Source id to the kernel |
| loc_rx_dest_o | output | 4 | Destination to the kernel (own id or broadcast) |
| loc_rx_user_o | output | 4 | User field to the kernel |
| loc_tx_valid_i | input | 1 | Kernel result beat valid |
| loc_tx_ready_o | output | 1 | Result beat accepted |
| loc_tx_data_i | input | 64 | Result data |
| loc_tx_keep_i | input | 8 | Result keep |
| loc_tx_last_i | input | 1 | Result last |
| loc_tx_dest_i | input | 4 | Result destination |
| rd_in_valid_i | input | 1 | Read-lane beat valid from the downstream stage |
| rd_in_ready_o | output | 1 | Read-lane ready to the downstream stage |
| rd_in_data_i | input | 64 | Read-lane data from downstream |
| rd_in_keep_i | input | 8 | Read-lane keep from downstream |
| rd_in_last_i | input | 1 | Read-lane last from downstream |
| rd_in_id_i | input | 4 | Read-lane id from downstream |
| rd_in_dest_i | input | 4 | Read-lane destination from downstream |
| rd_out_valid_o | output | 1 | Read-lane beat valid to the upstream stage |
| rd_out_ready_i | input | 1 | Upstream read-lane ready |
| rd_out_data_o | output | 64 | Read-lane data upstream |
| rd_out_keep_o | output | 8 | Read-lane keep upstream |
| rd_out_last_o | output | 1 | Read-lane last upstream |
| rd_out_id_o | output | 4 | Read-lane id upstream |
| rd_out_dest_o | output | 4 | Read-lane destination upstream |
| rd_tok_i | input | 4 | Access token from the upstream stage |
| rd_tok_o | output | 4 | Access token to the downstream stage |

## Verification
A wrong packet-ownership state in the read-lane merger shows at the ports within one beat. It appears as a local beat spliced into the middle of a forwarded packet, or the reverse, so the tests deliberately leave idle gaps inside packets while the token changes. A skid occupancy error shows as a third beat accepted by a stalled output, or as a lost or duplicated beat once the stall is released. A routing decode error shows on the cycle after acceptance, as a beat on the wrong output or a broadcast copy that is missing.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int DATA_W = 64;
  localparam int KEEP_W = DATA_W / 8;
  localparam int TAG_W  = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [KEEP_W-1:0] keep;
    logic              last;
    logic [TAG_W-1:0]  id;
    logic [TAG_W-1:0]  dest;
    logic [TAG_W-1:0]  user;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

  typedef enum logic [1:0] {OWN_NONE, OWN_FWD, OWN_LOC} own_e;
endpackage

// File: rtl/chain_skid.sv
module chain_skid #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  localparam int DEPTH = 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic             wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  assign in_ready_o  = (cnt_q != CNT_W'(DEPTH));
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem_q[rp_q];
  assign push = in_valid_i & in_ready_o;
  assign pop  = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= ~wp_q;
      if (pop)  rp_q <= ~rp_q;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= in_data_i;
  end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) && !out_ready_i |=> !in_ready_o);
endmodule

// File: rtl/chain_wr_route.sv
module chain_wr_route
  import chain_pkg::*;
#(
  parameter logic [TAG_W-1:0] SLAVE_ID = 4'd1,
  parameter logic [TAG_W-1:0] BCAST_ID = 4'hF
) (
  input  logic  in_valid_i,
  input  beat_t in_beat_i,
  output logic  in_ready_o,
  input  logic  loc_ready_i,
  input  logic  dn_ready_i,
  output logic  loc_push_o,
  output logic  dn_push_o
);
  logic is_bc, is_me;

  assign is_bc = (in_beat_i.dest == BCAST_ID);
  assign is_me = (in_beat_i.dest == SLAVE_ID);

  // broadcast moves only when both copies can land in the same cycle
  always_comb begin
    if (is_bc)      in_ready_o = loc_ready_i & dn_ready_i;
    else if (is_me) in_ready_o = loc_ready_i;
    else            in_ready_o = dn_ready_i;
  end

  assign loc_push_o = in_valid_i & in_ready_o & (is_bc | is_me);
  assign dn_push_o  = in_valid_i & in_ready_o & ~is_me;
endmodule

// File: rtl/chain_rd_merge.sv
module chain_rd_merge
  import chain_pkg::*;
#(
  parameter logic [TAG_W-1:0] SLAVE_ID = 4'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_valid_i,
  input  beat_t            rd_beat_i,
  output logic             rd_ready_o,
  input  logic             loc_valid_i,
  input  beat_t            loc_beat_i,
  output logic             loc_ready_o,
  input  logic [TAG_W-1:0] tok_i,
  output logic             up_valid_o,
  output beat_t            up_beat_o,
  input  logic             up_ready_i
);
  own_e own_q;
  logic sel_loc, sel_fwd, fire;

  // local gets the slot at a packet boundary when it holds the token
  always_comb begin
    sel_loc = 1'b0;
    sel_fwd = 1'b0;
    unique case (own_q)
      OWN_LOC: sel_loc = 1'b1;
      OWN_FWD: sel_fwd = 1'b1;
      default: begin
        sel_loc = loc_valid_i & (tok_i == SLAVE_ID);
        sel_fwd = ~sel_loc & rd_valid_i;
      end
    endcase
  end

  assign up_valid_o  = (sel_loc & loc_valid_i) | (sel_fwd & rd_valid_i);
  assign up_beat_o   = sel_loc ? loc_beat_i : rd_beat_i;
  assign rd_ready_o  = sel_fwd & up_ready_i;
  assign loc_ready_o = sel_loc & up_ready_i;
  assign fire        = up_valid_o & up_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= OWN_NONE;
    end else if (fire) begin
      if (up_beat_o.last) own_q <= OWN_NONE;
      else                own_q <= sel_loc ? OWN_LOC : OWN_FWD;
    end
  end

  assert_tok_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_NONE) && loc_valid_i && loc_ready_o |-> tok_i == SLAVE_ID);

  assert_fwd_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && rd_ready_o && !rd_beat_i.last |=> !loc_ready_o);

  assert_loc_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_i && loc_ready_o && !loc_beat_i.last |=> !rd_ready_o);

  assert_one_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ready_o, loc_ready_o}));
endmodule

// File: rtl/chain_tap.sv
module chain_tap
  import chain_pkg::*;
#(
  parameter logic [TAG_W-1:0] SLAVE_ID = 4'd1,
  parameter logic [TAG_W-1:0] BCAST_ID = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_in_valid_i,
  output logic              wr_in_ready_o,
  input  logic [DATA_W-1:0] wr_in_data_i,
  input  logic [KEEP_W-1:0] wr_in_keep_i,
  input  logic              wr_in_last_i,
  input  logic [TAG_W-1:0]  wr_in_id_i,
  input  logic [TAG_W-1:0]  wr_in_dest_i,
  input  logic [TAG_W-1:0]  wr_in_user_i,
  output logic              wr_out_valid_o,
  input  logic              wr_out_ready_i,
  output logic [DATA_W-1:0] wr_out_data_o,
  output logic [KEEP_W-1:0] wr_out_keep_o,
  output logic              wr_out_last_o,
  output logic [TAG_W-1:0]  wr_out_id_o,
  output logic [TAG_W-1:0]  wr_out_dest_o,
  output logic [TAG_W-1:0]  wr_out_user_o,
  output logic              loc_rx_valid_o,
  input  logic              loc_rx_ready_i,
  output logic [DATA_W-1:0] loc_rx_data_o,
  output logic [KEEP_W-1:0] loc_rx_keep_o,
  output logic              loc_rx_last_o,
  output logic [TAG_W-1:0]  loc_rx_id_o,
  output logic [TAG_W-1:0]  loc_rx_dest_o,
  output logic [TAG_W-1:0]  loc_rx_user_o,
  input  logic              loc_tx_valid_i,
  output logic              loc_tx_ready_o,
  input  logic [DATA_W-1:0] loc_tx_data_i,
  input  logic [KEEP_W-1:0] loc_tx_keep_i,
  input  logic              loc_tx_last_i,
  input  logic [TAG_W-1:0]  loc_tx_dest_i,
  input  logic              rd_in_valid_i,
  output logic              rd_in_ready_o,
  input  logic [DATA_W-1:0] rd_in_data_i,
  input  logic [KEEP_W-1:0] rd_in_keep_i,
  input  logic              rd_in_last_i,
  input  logic [TAG_W-1:0]  rd_in_id_i,
  input  logic [TAG_W-1:0]  rd_in_dest_i,
  output logic              rd_out_valid_o,
  input  logic              rd_out_ready_i,
  output logic [DATA_W-1:0] rd_out_data_o,
  output logic [KEEP_W-1:0] rd_out_keep_o,
  output logic              rd_out_last_o,
  output logic [TAG_W-1:0]  rd_out_id_o,
  output logic [TAG_W-1:0]  rd_out_dest_o,
  input  logic [TAG_W-1:0]  rd_tok_i,
  output logic [TAG_W-1:0]  rd_tok_o
);
  beat_t wr_beat, dn_beat, lrx_beat, ltx_beat, rdi_beat, up_in_beat, up_beat;
  logic  loc_push, dn_push, loc_rdy, dn_rdy;
  logic  up_in_valid, up_rdy;
  logic [TAG_W-1:0] tok_q;

  assign wr_beat = '{data: wr_in_data_i, keep: wr_in_keep_i, last: wr_in_last_i,
                     id: wr_in_id_i, dest: wr_in_dest_i, user: wr_in_user_i};

  chain_wr_route #(.SLAVE_ID(SLAVE_ID), .BCAST_ID(BCAST_ID)) u_route (
    .in_valid_i (wr_in_valid_i),
    .in_beat_i  (wr_beat),
    .in_ready_o (wr_in_ready_o),
    .loc_ready_i(loc_rdy),
    .dn_ready_i (dn_rdy),
    .loc_push_o (loc_push),
    .dn_push_o  (dn_push)
  );

  chain_skid #(.W(BEAT_W)) u_dn_hop (
    .clk_i, .rst_ni,
    .in_valid_i (dn_push),
    .in_ready_o (dn_rdy),
    .in_data_i  (wr_beat),
    .out_valid_o(wr_out_valid_o),
    .out_ready_i(wr_out_ready_i),
    .out_data_o (dn_beat)
  );

  chain_skid #(.W(BEAT_W)) u_loc_hop (
    .clk_i, .rst_ni,
    .in_valid_i (loc_push),
    .in_ready_o (loc_rdy),
    .in_data_i  (wr_beat),
    .out_valid_o(loc_rx_valid_o),
    .out_ready_i(loc_rx_ready_i),
    .out_data_o (lrx_beat)
  );

  assign wr_out_data_o = dn_beat.data;
  assign wr_out_keep_o = dn_beat.keep;
  assign wr_out_last_o = dn_beat.last;
  assign wr_out_id_o   = dn_beat.id;
  assign wr_out_dest_o = dn_beat.dest;
  assign wr_out_user_o = dn_beat.user;

  assign loc_rx_data_o = lrx_beat.data;
  assign loc_rx_keep_o = lrx_beat.keep;
  assign loc_rx_last_o = lrx_beat.last;
  assign loc_rx_id_o   = lrx_beat.id;
  assign loc_rx_dest_o = lrx_beat.dest;
  assign loc_rx_user_o = lrx_beat.user;

  // inserted results are stamped with this stage's id
  assign ltx_beat = '{data: loc_tx_data_i, keep: loc_tx_keep_i, last: loc_tx_last_i,
                      id: SLAVE_ID, dest: loc_tx_dest_i, user: '0};
  assign rdi_beat = '{data: rd_in_data_i, keep: rd_in_keep_i, last: rd_in_last_i,
                      id: rd_in_id_i, dest: rd_in_dest_i, user: '0};

  chain_rd_merge #(.SLAVE_ID(SLAVE_ID)) u_merge (
    .clk_i, .rst_ni,
    .rd_valid_i (rd_in_valid_i),
    .rd_beat_i  (rdi_beat),
    .rd_ready_o (rd_in_ready_o),
    .loc_valid_i(loc_tx_valid_i),
    .loc_beat_i (ltx_beat),
    .loc_ready_o(loc_tx_ready_o),
    .tok_i      (rd_tok_i),
    .up_valid_o (up_in_valid),
    .up_beat_o  (up_in_beat),
    .up_ready_i (up_rdy)
  );

  chain_skid #(.W(BEAT_W)) u_up_hop (
    .clk_i, .rst_ni,
    .in_valid_i (up_in_valid),
    .in_ready_o (up_rdy),
    .in_data_i  (up_in_beat),
    .out_valid_o(rd_out_valid_o),
    .out_ready_i(rd_out_ready_i),
    .out_data_o (up_beat)
  );

  assign rd_out_data_o = up_beat.data;
  assign rd_out_keep_o = up_beat.keep;
  assign rd_out_last_o = up_beat.last;
  assign rd_out_id_o   = up_beat.id;
  assign rd_out_dest_o = up_beat.dest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '0;
    else         tok_q <= rd_tok_i;
  end
  assign rd_tok_o = tok_q;

  assert_local_dest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_rx_valid_o |-> (loc_rx_dest_o == SLAVE_ID) || (loc_rx_dest_o == BCAST_ID));

  assert_bcast_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_push && (wr_in_dest_i == BCAST_ID) |-> dn_push);

  assert_bcast_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_in_valid_i && wr_in_ready_o && (wr_in_dest_i == BCAST_ID) |-> loc_rdy && dn_rdy);

  assert_unicast_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_push && (wr_in_dest_i != BCAST_ID) |-> !loc_push);
endmodule

// File: tb/tb_chain_tap.sv
module tb_chain_tap;
  import chain_pkg::*;

  localparam logic [3:0] MY_ID = 4'd3;
  localparam logic [3:0] BC_ID = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_in_valid_i = 0, wr_in_last_i = 0;
  logic [63:0] wr_in_data_i = 0;
  logic [7:0]  wr_in_keep_i = 0;
  logic [3:0]  wr_in_id_i = 0, wr_in_dest_i = 0, wr_in_user_i = 0;
  logic        wr_in_ready_o;
  logic        wr_out_valid_o, wr_out_ready_i = 1, wr_out_last_o;
  logic [63:0] wr_out_data_o;
  logic [7:0]  wr_out_keep_o;
  logic [3:0]  wr_out_id_o, wr_out_dest_o, wr_out_user_o;
  logic        loc_rx_valid_o, loc_rx_ready_i = 1, loc_rx_last_o;
  logic [63:0] loc_rx_data_o;
  logic [7:0]  loc_rx_keep_o;
  logic [3:0]  loc_rx_id_o, loc_rx_dest_o, loc_rx_user_o;
  logic        loc_tx_valid_i = 0, loc_tx_ready_o, loc_tx_last_i = 0;
  logic [63:0] loc_tx_data_i = 0;
  logic [7:0]  loc_tx_keep_i = 0;
  logic [3:0]  loc_tx_dest_i = 0;
  logic        rd_in_valid_i = 0, rd_in_ready_o, rd_in_last_i = 0;
  logic [63:0] rd_in_data_i = 0;
  logic [7:0]  rd_in_keep_i = 0;
  logic [3:0]  rd_in_id_i = 0, rd_in_dest_i = 0;
  logic        rd_out_valid_o, rd_out_ready_i = 1, rd_out_last_o;
  logic [63:0] rd_out_data_o;
  logic [7:0]  rd_out_keep_o;
  logic [3:0]  rd_out_id_o, rd_out_dest_o;
  logic [3:0]  rd_tok_i = 0, rd_tok_o;

  chain_tap #(.SLAVE_ID(MY_ID), .BCAST_ID(BC_ID)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_in_valid_i, .wr_in_ready_o, .wr_in_data_i, .wr_in_keep_i, .wr_in_last_i,
    .wr_in_id_i, .wr_in_dest_i, .wr_in_user_i,
    .wr_out_valid_o, .wr_out_ready_i, .wr_out_data_o, .wr_out_keep_o, .wr_out_last_o,
    .wr_out_id_o, .wr_out_dest_o, .wr_out_user_o,
    .loc_rx_valid_o, .loc_rx_ready_i, .loc_rx_data_o, .loc_rx_keep_o, .loc_rx_last_o,
    .loc_rx_id_o, .loc_rx_dest_o, .loc_rx_user_o,
    .loc_tx_valid_i, .loc_tx_ready_o, .loc_tx_data_i, .loc_tx_keep_i, .loc_tx_last_i,
    .loc_tx_dest_i,
    .rd_in_valid_i, .rd_in_ready_o, .rd_in_data_i, .rd_in_keep_i, .rd_in_last_i,
    .rd_in_id_i, .rd_in_dest_i,
    .rd_out_valid_o, .rd_out_ready_i, .rd_out_data_o, .rd_out_keep_o, .rd_out_last_o,
    .rd_out_id_o, .rd_out_dest_o,
    .rd_tok_i, .rd_tok_o
  );

  int n_chk = 0, n_fail = 0, in_acc = 0, cyc = 0;
  bit done = 0;
  beat_t dn_q[$], loc_q[$], up_q[$];

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (wr_in_valid_i && wr_in_ready_o) in_acc++;
    if (wr_out_valid_o && wr_out_ready_i)
      dn_q.push_back('{wr_out_data_o, wr_out_keep_o, wr_out_last_o, wr_out_id_o, wr_out_dest_o, wr_out_user_o});
    if (loc_rx_valid_o && loc_rx_ready_i)
      loc_q.push_back('{loc_rx_data_o, loc_rx_keep_o, loc_rx_last_o, loc_rx_id_o, loc_rx_dest_o, loc_rx_user_o});
    if (rd_out_valid_o && rd_out_ready_i)
      up_q.push_back('{rd_out_data_o, rd_out_keep_o, rd_out_last_o, rd_out_id_o, rd_out_dest_o, 4'h0});
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic clear_q();
    dn_q.delete(); loc_q.delete(); up_q.delete(); in_acc = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_beat(input logic [3:0] dest, input logic [63:0] d, input logic l);
    wr_in_valid_i = 1; wr_in_dest_i = dest; wr_in_data_i = d; wr_in_last_i = l;
    wr_in_keep_i = 8'hFF; wr_in_id_i = 4'h2; wr_in_user_i = 4'h5;
    @(negedge clk);
    while (!wr_in_ready_o) @(negedge clk);
    @(posedge clk); #1;
    wr_in_valid_i = 0;
  endtask

  task automatic loc_beat(input logic [63:0] d, input logic l);
    loc_tx_valid_i = 1; loc_tx_data_i = d; loc_tx_last_i = l;
    loc_tx_keep_i = 8'hFF; loc_tx_dest_i = 4'h0;
    @(negedge clk);
    while (!loc_tx_ready_o) @(negedge clk);
    @(posedge clk); #1;
    loc_tx_valid_i = 0;
  endtask

  task automatic rd_beat(input logic [63:0] d, input logic l);
    rd_in_valid_i = 1; rd_in_data_i = d; rd_in_last_i = l;
    rd_in_keep_i = 8'h0F; rd_in_id_i = 4'h9; rd_in_dest_i = 4'h0;
    @(negedge clk);
    while (!rd_in_ready_o) @(negedge clk);
    @(posedge clk); #1;
    rd_in_valid_i = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 wr_out_valid", wr_out_valid_o, 0);
    chk("R12 loc_rx_valid", loc_rx_valid_o, 0);
    chk("R12 rd_out_valid", rd_out_valid_o, 0);
    chk("R12 wr_in_ready", wr_in_ready_o, 1);
    chk("R12 rd_tok_o", rd_tok_o, 0);
  endtask

  task automatic t_unicast_local();
    clear_q();
    wr_beat(MY_ID, 64'h1111_0000_0000_0001, 1);
    idle(3);
    chk("R1 local count", loc_q.size(), 1);
    chk("R1 downstream count", dn_q.size(), 0);
    if (loc_q.size() == 1) begin
      chk("R1 local data", loc_q[0].data, 64'h1111_0000_0000_0001);
      chk("R1 local user", loc_q[0].user, 4'h5);
    end
  endtask

  task automatic t_forward();
    clear_q();
    for (int i = 0; i < 3; i++) wr_beat(4'd5, 64'hA0 + i, i == 2);
    idle(3);
    chk("R2 downstream count", dn_q.size(), 3);
    chk("R2 local count", loc_q.size(), 0);
    for (int i = 0; i < 3 && i < dn_q.size(); i++) begin
      chk("R2 data order", dn_q[i].data, 64'hA0 + i);
      chk("R2 tags", {dn_q[i].id, dn_q[i].dest, dn_q[i].user, dn_q[i].keep}, {4'h2, 4'd5, 4'h5, 8'hFF});
      chk("R2 last", dn_q[i].last, i == 2);
    end
  endtask

  task automatic t_bcast();
    clear_q();
    wr_beat(BC_ID, 64'hB0, 0);
    wr_beat(BC_ID, 64'hB1, 1);
    idle(3);
    chk("R3 local count", loc_q.size(), 2);
    chk("R3 downstream count", dn_q.size(), 2);
    if (loc_q.size() == 2 && dn_q.size() == 2) begin
      chk("R3 copies match 0", loc_q[0], dn_q[0]);
      chk("R3 copies match 1", loc_q[1], dn_q[1]);
      chk("R3 second data", loc_q[1].data, 64'hB1);
    end
  endtask

  task automatic t_bcast_stall();
    clear_q();
    loc_rx_ready_i = 0;
    fork
      for (int i = 0; i < 3; i++) wr_beat(BC_ID, 64'hC0 + i, i == 2);
      begin
        repeat (10) @(negedge clk);
        chk("R4 ready low on full local", wr_in_ready_o, 0);
        chk("R6 two beats accepted", in_acc, 2);
        chk("R4 downstream got only accepted", dn_q.size(), 2);
        @(posedge clk); #1;
        loc_rx_ready_i = 1;
      end
    join
    idle(4);
    chk("R6 local no loss", loc_q.size(), 3);
    chk("R4 downstream total", dn_q.size(), 3);
    for (int i = 0; i < 3 && i < loc_q.size(); i++)
      chk("R6 local order", loc_q[i].data, 64'hC0 + i);
  endtask

  task automatic t_latency_hold();
    clear_q();
    wr_out_ready_i = 0;
    wr_in_valid_i = 1; wr_in_dest_i = 4'd6; wr_in_data_i = 64'hD00D; wr_in_last_i = 1;
    @(negedge clk);
    chk("R5 not valid before edge", wr_out_valid_o, 0);
    @(posedge clk); #1;
    wr_in_valid_i = 0;
    @(negedge clk);
    chk("R5 valid after edge", wr_out_valid_o, 1);
    chk("R5 data after edge", wr_out_data_o, 64'hD00D);
    repeat (3) @(negedge clk);
    chk("R5 held valid", wr_out_valid_o, 1);
    chk("R5 held data", wr_out_data_o, 64'hD00D);
    @(posedge clk); #1;
    wr_out_ready_i = 1;
    idle(2);
    chk("R5 single delivery", dn_q.size(), 1);
  endtask

  task automatic t_throughput();
    int t0;
    clear_q();
    t0 = cyc;
    for (int i = 0; i < 8; i++) wr_beat(4'd7, 64'hE0 + i, i == 7);
    chk("R6 one beat per cycle", cyc - t0, 8);
    idle(3);
    chk("R6 streamed count", dn_q.size(), 8);
    for (int i = 0; i < 8 && i < dn_q.size(); i++)
      chk("R6 streamed order", dn_q[i].data, 64'hE0 + i);
  endtask

  task automatic t_token();
    clear_q();
    rd_tok_i = 4'd2;
    fork
      begin loc_beat(64'hF0, 0); loc_beat(64'hF1, 1); end
      begin
        repeat (6) @(negedge clk);
        chk("R7 blocked without token", loc_tx_ready_o, 0);
        chk("R7 nothing inserted", up_q.size(), 0);
        @(posedge clk); #1;
        rd_tok_i = MY_ID;
      end
    join
    idle(3);
    chk("R7 inserted after token", up_q.size(), 2);
    if (up_q.size() == 2) begin
      chk("R10 id stamped", up_q[0].id, MY_ID);
      chk("R10 dest from kernel", up_q[1].dest, 4'h0);
      chk("R7 second beat data", up_q[1].data, 64'hF1);
    end
  endtask

  task automatic t_fwd_lock();
    clear_q();
    rd_tok_i = 4'd0;
    fork
      begin
        rd_beat(64'h10, 0);
        idle(3);
        rd_beat(64'h11, 0);
        rd_beat(64'h12, 1);
      end
      begin
        @(posedge clk); #1;
        rd_tok_i = MY_ID;
        loc_beat(64'h1F, 1);
      end
    join
    idle(3);
    chk("R8 count", up_q.size(), 4);
    if (up_q.size() == 4) begin
      chk("R8 order 0", up_q[0].data, 64'h10);
      chk("R8 order 1", up_q[1].data, 64'h11);
      chk("R8 order 2", up_q[2].data, 64'h12);
      chk("R8 local after last", up_q[3].data, 64'h1F);
      chk("R10 forwarded id kept", up_q[1].id, 4'h9);
      chk("R10 forwarded keep", up_q[0].keep, 8'h0F);
    end
  endtask

  task automatic t_loc_lock();
    clear_q();
    rd_tok_i = MY_ID;
    fork
      begin
        loc_beat(64'h20, 0);
        idle(2);
        loc_beat(64'h21, 0);
        loc_beat(64'h22, 1);
      end
      begin
        @(posedge clk); #1;
        rd_tok_i = 4'd0;
        rd_beat(64'h2E, 1);
      end
    join
    idle(3);
    chk("R9 count", up_q.size(), 4);
    if (up_q.size() == 4) begin
      chk("R9 order 1", up_q[1].data, 64'h21);
      chk("R9 order 2", up_q[2].data, 64'h22);
      chk("R9 downstream after last", up_q[3].data, 64'h2E);
    end
  endtask

  task automatic t_token_pass();
    rd_tok_i = 4'd4;
    idle(1);
    rd_tok_i = 4'd7;
    @(negedge clk);
    chk("R11 one-cycle delay old", rd_tok_o, 4'd4);
    @(negedge clk);
    chk("R11 one-cycle delay new", rd_tok_o, 4'd7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1;
    idle(2);
    t_unicast_local();
    t_forward();
    t_bcast();
    t_bcast_stall();
    t_latency_hold();
    t_throughput();
    t_token();
    t_fwd_lock();
    t_loc_lock();
    t_token_pass();
    done = 1;
    summary();
    $finish;
  end
endmodule